// File: doc/BRIEF.md
# Tag Check Fault Reporting Dispatcher

This block receives one tag-check failure event per cycle and decides how that failure is reported. Each event carries the faulting address, whether the access was a store, whether it came from an unprivileged user context, the level that controls the translation regime, the current level, whether the regime has two address ranges, and the 64-bit system control word that governs the context. A 2-bit reporting mode is taken from that control word. Depending on the mode, the block raises a synchronous data-abort request, sets a sticky bit in an asynchronous fault status register, or does nothing.

There is one asynchronous status register per level. Each register holds two sticky flag bits, one for each address range. A plain register port reads these registers and overwrites them, so software can clear or set bits explicitly. The synchronous request is a registered one-cycle pulse. It carries the syndrome fields and the faulting address.

Top module: `tag_fault_router`

## Requirements
- R1: After reset, all four status registers read zero and `sync_req` is low.
- R2: When `evt_user` is 1, the mode is `evt_ctrl[39:38]` and any asynchronous flag lands in the level-0 status register.
- R3: When `evt_user` is 0, the mode is `evt_ctrl[41:40]` and any asynchronous flag lands in the status register selected by `evt_ctrl_lvl`.
- R4: Mode 0 (ignore) has no effect. No `sync_req` pulse is produced and every status register keeps its value.
- R5: Mode 1 (synchronous) makes `sync_req` high for exactly the one cycle after the event. During that cycle `sync_addr` equals `evt_addr`, `sync_fsc` is 6'h11, `sync_write` equals `evt_write`, and `sync_lower` is 1 exactly when `evt_cur_lvl` is nonzero. No status bit changes.
- R6: Mode 2 (asynchronous) sets one flag bit in the target status register from the next cycle onward. No `sync_req` pulse is produced.
- R7: Mode 3 (split) behaves as mode 2 for stores (`evt_write`=1) and as mode 1 for loads.
- R8: The flag bit index is `evt_addr[55]` when `evt_two_ranges` is 1, and 0 otherwise. The flag is ORed into the register, so it is sticky, and other bits are kept.
- R9: A register write (`reg_wr`) replaces the selected register with `reg_wdata`. If a flag set hits the same register in the same cycle, the set bit is ORed on top of the written value.
- R10: With no event, `sync_req` is low in the following cycle, and `sync_fsc` is zero whenever `sync_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Failure event present this cycle |
| evt_addr | input | 64 | Faulting address |
| evt_write | input | 1 | 1 for a store, 0 for a load |
| evt_user | input | 1 | Unprivileged user context |
| evt_ctrl_lvl | input | 2 | Level that controls the regime |
| evt_cur_lvl | input | 2 | Current level |
| evt_two_ranges | input | 1 | Regime has two address ranges |
| evt_ctrl | input | 64 | System control word for the context |
| reg_wr | input | 1 | Status register write strobe |
| reg_sel | input | 2 | Status register select |
| reg_wdata | input | 2 | Status write data |
| reg_rdata | output | 2 | Selected status register value |
| sync_req | output | 1 | Synchronous abort request pulse |
| sync_addr | output | 64 | Fault address of the request |
| sync_fsc | output | 6 | Fault status code |
| sync_write | output | 1 | Write indication of the request |
| sync_lower | output | 1 | Fault taken from a nonzero current level |

## Verification
A software register write and a hardware flag set can both target the same status register in the same cycle. The bench provokes this by asserting `reg_wr` and an asynchronous-mode event together on one level. It does so with the written value and the set bit disjoint, and again with them overlapping. It then reads the register back and expects the written value ORed with the set bit. The bench also sweeps every combination of context, mode, direction, range flag, address bit 55 and level. Before each case it clears all status registers, and after each case it reads back all four registers, so a wrong field, a wrong level or a wrong bit cannot go unnoticed.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  typedef enum logic [1:0] {
    TCF_IGNORE = 2'd0,
    TCF_SYNC   = 2'd1,
    TCF_ASYNC  = 2'd2,
    TCF_SPLIT  = 2'd3
  } tcf_mode_e;

  // Action derived from mode and access direction: {sync, async}
  function automatic logic [1:0] mode_action(input tcf_mode_e m, input logic wr);
    logic s, a;
    s = (m == TCF_SYNC)  || ((m == TCF_SPLIT) && !wr);
    a = (m == TCF_ASYNC) || ((m == TCF_SPLIT) &&  wr);
    return {s, a};
  endfunction

  // Index of the sticky flag bit within a status register
  function automatic logic flag_index(input logic two_ranges, input logic addr_bit);
    return two_ranges & addr_bit;
  endfunction
endpackage

// File: rtl/tfr_mode_decode.sv
module tfr_mode_decode
  import tfr_pkg::*;
#(
  parameter int CTRL_W   = 64,
  parameter int USER_LSB = 38,
  parameter int PRIV_LSB = 40,
  parameter int LVL_W    = 2,
  parameter int FLAG_W   = 2
) (
  input  logic              evt_valid,
  input  logic [CTRL_W-1:0] evt_ctrl,
  input  logic              evt_user,
  input  logic              evt_write,
  input  logic              evt_two_ranges,
  input  logic              evt_range_bit,
  input  logic [LVL_W-1:0]  evt_ctrl_lvl,
  output logic              act_sync,
  output logic              act_async,
  output logic [LVL_W-1:0]  tgt_lvl,
  output logic [FLAG_W-1:0] set_mask
);
  tcf_mode_e  mode;
  logic [1:0] act;
  logic       idx;

  always_comb begin
    mode     = evt_user ? tcf_mode_e'(evt_ctrl[USER_LSB+1:USER_LSB])
                        : tcf_mode_e'(evt_ctrl[PRIV_LSB+1:PRIV_LSB]);
    act      = mode_action(mode, evt_write);
    act_sync  = evt_valid & act[1];
    act_async = evt_valid & act[0];
    tgt_lvl  = evt_user ? '0 : evt_ctrl_lvl;
    idx      = flag_index(evt_two_ranges, evt_range_bit);
    set_mask = '0;
    set_mask[idx] = 1'b1;
  end
endmodule

// File: rtl/tfr_status_bank.sv
module tfr_status_bank #(
  parameter int NUM_LVL = 4,
  parameter int FLAG_W  = 2,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [LVL_W-1:0]  set_lvl,
  input  logic [FLAG_W-1:0] set_mask,
  input  logic              reg_wr,
  input  logic [LVL_W-1:0]  reg_sel,
  input  logic [FLAG_W-1:0] reg_wdata,
  output logic [FLAG_W-1:0] reg_rdata
);
  logic [FLAG_W-1:0] st [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic [FLAG_W-1:0] q;
    logic              wr_hit, set_hit;
    assign wr_hit  = reg_wr && (reg_sel == LVL_W'(g));
    assign set_hit = set_en && (set_lvl == LVL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (wr_hit || set_hit) q <= (wr_hit ? reg_wdata : q) | (set_hit ? set_mask : '0);
    end
    assign st[g] = q;
  end

  assign reg_rdata = st[reg_sel];
endmodule

// File: rtl/tfr_sync_out.sv
module tfr_sync_out #(
  parameter int          ADDR_W = 64,
  parameter int          LVL_W  = 2,
  parameter logic [5:0]  FSC    = 6'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [LVL_W-1:0]  cur_lvl,
  output logic              req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [5:0]        req_fsc,
  output logic              req_write,
  output logic              req_lower
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req       <= 1'b0;
      req_addr  <= '0;
      req_fsc   <= '0;
      req_write <= 1'b0;
      req_lower <= 1'b0;
    end else begin
      req     <= fire;
      req_fsc <= fire ? FSC : 6'h0;
      if (fire) begin
        req_addr  <= addr;
        req_write <= wr;
        req_lower <= (cur_lvl != '0);
      end
    end
  end
endmodule

// File: rtl/tag_fault_router.sv
module tag_fault_router #(
  parameter int ADDR_W    = 64,
  parameter int CTRL_W    = 64,
  parameter int NUM_LVL   = 4,
  parameter int FLAG_W    = 2,
  parameter int RANGE_BIT = 55,
  parameter int USER_LSB  = 38,
  parameter int PRIV_LSB  = 40,
  localparam int LVL_W    = $clog2(NUM_LVL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              evt_write,
  input  logic              evt_user,
  input  logic [LVL_W-1:0]  evt_ctrl_lvl,
  input  logic [LVL_W-1:0]  evt_cur_lvl,
  input  logic              evt_two_ranges,
  input  logic [CTRL_W-1:0] evt_ctrl,
  input  logic              reg_wr,
  input  logic [LVL_W-1:0]  reg_sel,
  input  logic [FLAG_W-1:0] reg_wdata,
  output logic [FLAG_W-1:0] reg_rdata,
  output logic              sync_req,
  output logic [ADDR_W-1:0] sync_addr,
  output logic [5:0]        sync_fsc,
  output logic              sync_write,
  output logic              sync_lower
);
  logic              act_sync, act_async;
  logic [LVL_W-1:0]  tgt_lvl;
  logic [FLAG_W-1:0] set_mask;

  tfr_mode_decode #(
    .CTRL_W(CTRL_W), .USER_LSB(USER_LSB), .PRIV_LSB(PRIV_LSB),
    .LVL_W(LVL_W), .FLAG_W(FLAG_W)
  ) u_dec (
    .evt_valid(evt_valid), .evt_ctrl(evt_ctrl), .evt_user(evt_user),
    .evt_write(evt_write), .evt_two_ranges(evt_two_ranges),
    .evt_range_bit(evt_addr[RANGE_BIT]), .evt_ctrl_lvl(evt_ctrl_lvl),
    .act_sync(act_sync), .act_async(act_async),
    .tgt_lvl(tgt_lvl), .set_mask(set_mask)
  );

  tfr_status_bank #(.NUM_LVL(NUM_LVL), .FLAG_W(FLAG_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .set_en(act_async), .set_lvl(tgt_lvl), .set_mask(set_mask),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  tfr_sync_out #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .fire(act_sync), .addr(evt_addr), .wr(evt_write), .cur_lvl(evt_cur_lvl),
    .req(sync_req), .req_addr(sync_addr), .req_fsc(sync_fsc),
    .req_write(sync_write), .req_lower(sync_lower)
  );
endmodule

// File: rtl/tfr_chk.sv
module tfr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_valid,
  input logic        evt_write,
  input logic        evt_user,
  input logic [63:0] evt_ctrl,
  input logic        act_sync,
  input logic        act_async,
  input logic        sync_req,
  input logic [5:0]  sync_fsc
);
  logic [1:0] seen_mode;
  assign seen_mode = evt_user ? evt_ctrl[39:38] : evt_ctrl[41:40];

  // R4
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && seen_mode == 2'd0) |=> !sync_req);

  // R5
  sync_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |-> sync_fsc == 6'h11);

  // R7
  split_store_async_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && seen_mode == 2'd3 && evt_write) |=> !sync_req);

  // R7
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_sync && act_async));

  // R10
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> !sync_req);

  // R10
  fsc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_req |-> sync_fsc == 6'h0);
endmodule

bind tag_fault_router tfr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_write(evt_write),
  .evt_user(evt_user), .evt_ctrl(evt_ctrl), .act_sync(act_sync),
  .act_async(act_async), .sync_req(sync_req), .sync_fsc(sync_fsc)
);

// File: tb/tag_fault_router_tb.sv
module tag_fault_router_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        evt_valid = 0;
  logic [63:0] evt_addr = '0;
  logic        evt_write = 0;
  logic        evt_user = 0;
  logic [1:0]  evt_ctrl_lvl = '0;
  logic [1:0]  evt_cur_lvl = '0;
  logic        evt_two_ranges = 0;
  logic [63:0] evt_ctrl = '0;
  logic        reg_wr = 0;
  logic [1:0]  reg_sel = '0;
  logic [1:0]  reg_wdata = '0;
  logic [1:0]  reg_rdata;
  logic        sync_req;
  logic [63:0] sync_addr;
  logic [5:0]  sync_fsc;
  logic        sync_write;
  logic        sync_lower;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tag_fault_router u_dut (.*);

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] l, input logic [1:0] v);
    @(negedge clk);
    reg_wr = 1; reg_sel = l; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic read_reg(input logic [1:0] l, output logic [1:0] v);
    reg_sel = l;
    #0.5;
    v = reg_rdata;
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [1:0] rv;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", sync_req, 0);
    for (int l = 0; l < 4; l++) begin
      read_reg(2'(l), rv);
      check("R1", rv, 0);
    end
    rst_n = 1;

    for (int c = 0; c < 256; c++) begin
      logic u, w, two, a55, es, ea;
      logic [1:0] m, lvl, cur, tl;
      logic [1:0] exp_st [4];
      string tag;
      u = c[0]; m = c[2:1]; w = c[3]; two = c[4]; a55 = c[5]; lvl = c[7:6];
      cur = lvl + 2'(u) + 2'd1;
      es = (m == 2'd1) || (m == 2'd3 && !w);
      ea = (m == 2'd2) || (m == 2'd3 && w);
      tl = u ? 2'd0 : lvl;
      tag = (m == 0) ? "R4" : (m == 1) ? "R5" : (m == 2) ? "R6" : "R7";
      for (int l = 0; l < 4; l++) begin
        write_reg(2'(l), 2'b00);
        exp_st[l] = 2'b00;
      end
      if (ea) exp_st[tl][two & a55] = 1'b1;
      @(negedge clk);
      evt_valid = 1; evt_write = w; evt_user = u; evt_ctrl_lvl = lvl;
      evt_cur_lvl = cur; evt_two_ranges = two;
      evt_addr = 64'h0123_4567_89AB_CDE0 ^ {56'(c), 8'h00};
      evt_addr[55] = a55;
      // selected field holds the mode; the other field holds its complement
      evt_ctrl = 64'h0;
      evt_ctrl[39:38] = u ? m : ~m;
      evt_ctrl[41:40] = u ? ~m : m;
      @(negedge clk);
      evt_valid = 0;
      check(tag, sync_req, es);
      if (es) begin
        check("R5", {sync_addr, sync_fsc, sync_write, sync_lower},
              {evt_addr, 6'h11, w, cur != 2'd0});
      end
      for (int l = 0; l < 4; l++) begin
        read_reg(2'(l), rv);
        // R2 R3 R8: target level and flag bit
        check(u ? "R2/R8" : "R3/R8", rv, exp_st[l]);
      end
      @(negedge clk);
      check("R10", {sync_req, sync_fsc}, 7'h0);
    end

    // R8 sticky: set bit0 twice, then bit1, at level 1
    write_reg(2'd1, 2'b00);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      evt_valid = 1; evt_user = 0; evt_ctrl_lvl = 2'd1; evt_write = 0;
      evt_two_ranges = 1; evt_ctrl = 64'h0; evt_ctrl[41:40] = 2'd2;
      evt_addr = 64'h0; evt_addr[55] = (k == 2);
    end
    @(negedge clk);
    evt_valid = 0;
    read_reg(2'd1, rv);
    check("R8", rv, 2'b11);

    // R9 same-cycle write and set, disjoint bits then overlapping bits
    for (int k = 0; k < 2; k++) begin
      write_reg(2'd2, 2'b10);
      @(negedge clk);
      reg_wr = 1; reg_sel = 2'd2; reg_wdata = (k == 0) ? 2'b00 : 2'b01;
      evt_valid = 1; evt_user = 0; evt_ctrl_lvl = 2'd2; evt_write = 1;
      evt_two_ranges = 1; evt_ctrl = 64'h0; evt_ctrl[41:40] = 2'd3;
      evt_addr = 64'h0; evt_addr[55] = 1'b0;
      @(negedge clk);
      reg_wr = 0; evt_valid = 0;
      read_reg(2'd2, rv);
      check("R9", rv, 2'b01);
    end
    // R9 plain write of a set value with no event
    write_reg(2'd3, 2'b11);
    read_reg(2'd3, rv);
    check("R9", rv, 2'b11);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule